// File: doc/BRIEF.md
# EEPROM Random-Read Sequencer

This block fetches a single byte from a serial EEPROM without any processor help, typically at boot before software runs. It acts as the host of an I2C master controller's byte-wide register port: it resets and configures the controller, then moves it through a random-read transaction. Before each step it waits for the controller's interrupt flag, and after each step it compares the controller's status code with the one value that step should produce.

A `go` strobe starts a transaction for an 11-bit byte address. Address bits 10:8 go into the device-select byte and bits 7:0 are sent as the word address. After a repeated start, one byte is received with a not-acknowledge. A stop is issued whether or not the read succeeded. The block then raises `done` for one clock, together with the received byte, or with `err` set and the byte forced to 0xFF if any status code differed from the expected one.

Top module: `eeprom_rd_seq`

## Requirements
- R1: After an accepted `go`, the first three register writes are, in order: select 0 (controller reset) with 0x00, select 1 (clock divider) with 0x24, and select 2 (control) with 0x40 (bus enable).
- R2: The first transaction step writes control with the start bit (0x20) set and expects status 0x08.
- R3: The second step writes select 3 (data) with 0xA0 OR (address bits 10:8 shifted left by one), then writes control, and expects status 0x18.
- R4: The third step writes the data register with address bits 7:0 and expects status 0x28.
- R5: The fourth step writes control with the start bit set (repeated start) and expects 0x10. The fifth step writes the data register with the device byte of R3 plus bit 0 set (read), and expects 0x40.
- R6: The sixth step writes control with the acknowledge bit (0x04) clear and expects 0x58. The byte then read from select 3 is presented on `data_out` with `err` low.
- R7: A status code that differs from the expected one at any step ends the transaction at once: no further step is started, `err` is high and `data_out` is 0xFF at `done`.
- R8: The status register (a read of select 1) is read only in the cycle after a control read (select 2) that returned the interrupt flag (bit 3) set. The control register is polled for as long as the flag stays clear.
- R9: Every transaction, whether it passes or fails, writes control with the stop bit (0x10) in the cycle before `done`.
- R10: `done` is high for exactly one clock per accepted transaction. A `go` that arrives while a transaction is in progress is ignored.
- R11: During and after reset the block makes no bus access, and `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe, one clock |
| byte_addr | input | 11 | EEPROM byte address, sampled with `go` |
| data_out | output | 8 | Byte read, or 0xFF on error; valid with `done` |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Transaction aborted on a status mismatch |
| bus_wr | output | 1 | Controller register write strobe |
| bus_rd | output | 1 | Controller register read strobe |
| bus_sel | output | 2 | Register select: 0 reset, 1 divider/status, 2 control, 3 data |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the cycle `bus_rd` is high |

## Verification
The hardest case to reach is a wrong status code at a chosen step, especially the last ones, where the sequencer has already done a repeated start and an address phase. The bench's controller model counts the control-register kicks and returns a bad code only at a selectable kick index, so each of the six steps is forced to fail in turn. The model's flag latency is varied so that the polling loop runs for zero or several cycles.

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq #(
  parameter logic [7:0] CLK_DIV  = 8'h24,
  parameter logic [3:0] DEV_TYPE = 4'hA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [10:0] byte_addr,
  output logic [7:0]  data_out,
  output logic        done,
  output logic        err,
  output logic        bus_wr,
  output logic        bus_rd,
  output logic [1:0]  bus_sel,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata
);
  localparam logic [1:0] SEL_RST = 2'd0, SEL_DIV = 2'd1, SEL_CTL = 2'd2, SEL_DAT = 2'd3;
  localparam logic [7:0] C_EN = 8'h40, C_START = 8'h20, C_STOP = 8'h10;
  localparam int FLAG_BIT = 3;
  localparam logic [2:0] LAST = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_DIV, S_EN, S_DATA, S_KICK, S_POLL, S_STAT, S_FETCH, S_STOP, S_DONE
  } st_t;

  st_t        st;
  logic [2:0] step;
  logic [10:0] addr_q;
  logic [7:0] byte_q;
  logic       err_q;

  logic [7:0] dev_byte, exp_code, ctl_val, dat_val;
  logic       has_data;

  assign dev_byte = {DEV_TYPE, addr_q[10:8], 1'b0};

  always_comb begin
    has_data = 1'b0;
    dat_val  = 8'h00;
    ctl_val  = C_EN;
    exp_code = 8'h00;
    case (step)
      3'd0: begin ctl_val = C_EN | C_START; exp_code = 8'h08; end
      3'd1: begin has_data = 1'b1; dat_val = dev_byte; exp_code = 8'h18; end
      3'd2: begin has_data = 1'b1; dat_val = addr_q[7:0]; exp_code = 8'h28; end
      3'd3: begin ctl_val = C_EN | C_START; exp_code = 8'h10; end
      3'd4: begin has_data = 1'b1; dat_val = dev_byte | 8'h01; exp_code = 8'h40; end
      default: begin exp_code = 8'h58; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step   <= 3'd0;
      addr_q <= '0;
      byte_q <= 8'h00;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st     <= S_RST;
          addr_q <= byte_addr;
          step   <= 3'd0;
          err_q  <= 1'b0;
        end
        S_RST:  st <= S_DIV;
        S_DIV:  st <= S_EN;
        S_EN:   st <= S_KICK;
        S_DATA: st <= S_KICK;
        S_KICK: st <= S_POLL;
        S_POLL: if (bus_rdata[FLAG_BIT]) st <= S_STAT;
        S_STAT: begin
          if (bus_rdata != exp_code) begin
            err_q  <= 1'b1;
            byte_q <= 8'hFF;
            st     <= S_STOP;
          end else if (step == LAST) begin
            st <= S_FETCH;
          end else begin
            step <= step + 3'd1;
            st   <= (step == 3'd0 || step == 3'd1 || step == 3'd3) ? S_DATA : S_KICK;
          end
        end
        S_FETCH: begin byte_q <= bus_rdata; st <= S_STOP; end
        S_STOP:  st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_sel   = SEL_CTL;
    bus_wdata = 8'h00;
    case (st)
      S_RST:   begin bus_wr = 1'b1; bus_sel = SEL_RST; end
      S_DIV:   begin bus_wr = 1'b1; bus_sel = SEL_DIV; bus_wdata = CLK_DIV; end
      S_EN:    begin bus_wr = 1'b1; bus_wdata = C_EN; end
      S_DATA:  begin bus_wr = has_data; bus_sel = SEL_DAT; bus_wdata = dat_val; end
      S_KICK:  begin bus_wr = 1'b1; bus_wdata = ctl_val; end
      S_POLL:  bus_rd = 1'b1;
      S_STAT:  begin bus_rd = 1'b1; bus_sel = SEL_DIV; end
      S_FETCH: begin bus_rd = 1'b1; bus_sel = SEL_DAT; end
      S_STOP:  begin bus_wr = 1'b1; bus_wdata = C_EN | C_STOP; end
      default: ;
    endcase
  end

  assign done     = (st == S_DONE);
  assign err      = err_q;
  assign data_out = byte_q;

  // R1
  init_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_DIV) |-> $past(bus_wr && bus_sel == SEL_RST));
  // R7
  err_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> data_out == 8'hFF);
  // R8
  stat_after_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel == SEL_DIV) |-> $past(bus_rd && bus_sel == SEL_CTL && bus_rdata[FLAG_BIT]));
  // R9
  stop_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_wr && bus_sel == SEL_CTL && bus_wdata[4]));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_eeprom_rd_seq.sv
module sim_eeprom_rd_seq;
  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [10:0] byte_addr = '0;
  logic [7:0] data_out, bus_wdata, bus_rdata;
  logic done, err, bus_wr, bus_rd;
  logic [1:0] bus_sel;

  always #2.5 clk = ~clk;

  eeprom_rd_seq u0 (.clk(clk), .rst_n(rst_n), .go(go), .byte_addr(byte_addr),
    .data_out(data_out), .done(done), .err(err), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rom(input logic [10:0] a);
    return a[7:0] ^ {a[10:8], 5'h15};
  endfunction

  // controller model
  logic [10:0] cur_addr = '0;
  int lat = 0, fail_at = -1;
  logic flag = 0, pend = 0;
  logic [7:0] status = 8'h00;
  int cnt = 0, kick = 0, wr_idx = 0, stop_cnt = 0, rst_cnt = 0, done_cnt = 0;
  logic [7:0] codes [6] = '{8'h08, 8'h18, 8'h28, 8'h10, 8'h40, 8'h58};
  logic [7:0] dev_w;

  assign dev_w = 8'hA0 | {4'h0, cur_addr[10:8], 1'b0};
  assign bus_rdata = (bus_sel == 2'd2) ? (8'h40 | {4'h0, flag, 3'b0}) :
                     (bus_sel == 2'd1) ? status : rom(cur_addr);

  always @(posedge clk) begin
    if (bus_rd && bus_sel == 2'd1)
      chk(flag, "R8 status read with flag clear", 0, 1);
    if (pend) begin
      if (cnt == 0) begin
        flag <= 1'b1; pend <= 1'b0;
        status <= (kick - 1 == fail_at) ? 8'hF8 : codes[(kick - 1) % 6];
      end else cnt <= cnt - 1;
    end
    if (bus_wr) begin
      case (wr_idx)
        0: chk(bus_sel == 2'd0 && bus_wdata == 8'h00, "R1 write0", {bus_sel, bus_wdata}, 10'h000);
        1: chk(bus_sel == 2'd1 && bus_wdata == 8'h24, "R1 write1", {bus_sel, bus_wdata}, 10'h124);
        2: chk(bus_sel == 2'd2 && bus_wdata == 8'h40, "R1 write2", {bus_sel, bus_wdata}, 10'h240);
        default: ;
      endcase
      wr_idx <= wr_idx + 1;
      if (bus_sel == 2'd0) begin rst_cnt <= rst_cnt + 1; kick <= 0; wr_idx <= 1; end
      if (bus_sel == 2'd3) begin
        if (kick == 1) chk(bus_wdata == dev_w, "R3 device write byte", bus_wdata, dev_w);
        else if (kick == 2) chk(bus_wdata == cur_addr[7:0], "R4 low address", bus_wdata, cur_addr[7:0]);
        else if (kick == 4) chk(bus_wdata == (dev_w | 8'h01), "R5 device read byte", bus_wdata, dev_w | 8'h01);
      end
      if (bus_sel == 2'd2 && bus_wdata[4]) begin
        stop_cnt <= stop_cnt + 1; flag <= 1'b0;
      end else if (bus_sel == 2'd2 && (bus_wdata[5] || flag)) begin
        if (kick == 0) chk(bus_wdata[5], "R2 start bit", bus_wdata, 8'h60);
        if (kick == 3) chk(bus_wdata[5], "R5 repeated start bit", bus_wdata, 8'h60);
        if (kick == 5) chk(!bus_wdata[2], "R6 ack bit clear", bus_wdata, 8'h40);
        if (fail_at >= 0) chk(kick <= fail_at, "R7 step after mismatch", kick, fail_at);
        flag <= 1'b0; pend <= 1'b1; cnt <= lat; kick <= kick + 1;
      end
    end
  end

  // scoreboard
  logic [8:0] expq [$];
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt++;
      if (expq.size() == 0) chk(0, "R10 unexpected done", 1, 0);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk({err, data_out} == e, e[8] ? "R7 error result" : "R6 read result", {err, data_out}, e);
        chk(stop_cnt == done_cnt, "R9 stop before done", stop_cnt, done_cnt);
      end
    end
  end

  task automatic run(input logic [10:0] a, input int l, input int f, input bit reissue);
    cur_addr = a; lat = l; fail_at = f;
    expq.push_back(f >= 0 ? 9'h1FF : {1'b0, rom(a)});
    @(negedge clk); byte_addr = a; go = 1'b1;
    @(negedge clk); go = 1'b0; byte_addr = ~a;
    if (reissue) begin
      repeat (4) @(negedge clk);
      go = 1'b1; @(negedge clk); go = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
    repeat (2) @(negedge clk);
  endtask

  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      chk(0, "watchdog expired", cyc, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_wr && !bus_rd && !done && !err, "R11 reset state", {bus_wr, bus_rd, done, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_wr && !bus_rd && !done && !err, "R11 idle after reset", {bus_wr, bus_rd, done, err}, 0);
    run(11'h000, 0, -1, 0);
    run(11'h7FF, 3, -1, 0);
    run(11'h355, 1, -1, 1);
    run(11'h4A2, 5, -1, 0);
    for (int s = 0; s < 6; s++) run(11'h123 + 11'(s * 97), s % 3, s, 0);
    run(11'h2C9, 2, -1, 1);
    chk(rst_cnt == 11, "R10 busy go ignored", rst_cnt, 11);
    chk(done_cnt == 11 && expq.size() == 0, "R10 done count", done_cnt, 11);
    chk(stop_cnt == 11, "R9 stop count", stop_cnt, 11);
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule